// File: doc/BRIEF.md
# Test Access Port Controller with Per-Bit Control Instruction Register

This block is a serial test access port for a large chip. It is driven by four serial pins: test clock, mode select, data in and data out. A mode-select bit sampled on each rising test-clock edge steps a sixteen-state controller. That controller decides whether serial data moves through the instruction register or through a data register.

The instruction register here is not an opcode. Each of its 25 bits is a separate control line, such as a test-mode enable or a data-register select. The bits are fed to the rest of the chip through a shadow copy, so the lines change only when a new instruction is committed. The top bit picks the data path: an external data register hooked to this block, or the one-bit bypass stage.

The test reset pin is gated by the chip's system reset. It takes effect only while both resets are held low.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: On each rising `tck_i` edge the controller moves to the next state set by `tms_i`, following the standard 16-state test access port graph. The state code on `state_o` is: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R2: Five consecutive rising edges with `tms_i`=1 bring the controller to state 0 from any state.
- R3: The controller and the shadow are reset asynchronously, to state 0 and all-zero controls, only while `rst_ni` and `trst_ni` are both low. `trst_ni` low alone has no effect, and `rst_ni` low alone has no effect.
- R4: In capture-IR the shift stage loads 1 into bit 0, 0 into bit 1, and 0 into every higher bit. The first two bits seen on `tdo_o` in shift-IR are therefore 1 and then 0.
- R5: In shift-IR the shift stage moves toward bit 0 and leaves bit 0 on `tdo_o`, so the least significant bit goes out first. `tdi_i` enters bit 24. When more than 25 bits are shifted, only the last 25 are kept: the first bit shifted lands in `ctrl_o[0]` after a 25-bit scan, and the last bit shifted always lands in `ctrl_o[24]`.
- R6: `ctrl_o` changes only on the rising edge that leaves update-IR. It keeps its value through capture-IR, shift-IR, the exit and pause states, and while the controller sits in update-IR.
- R7: Each rising edge spent in state 0 loads `ctrl_o` with all zeros, which deasserts every control and selects bypass.
- R8: When `ctrl_o[24]`=0, the data path in shift-DR is the one-bit bypass stage. Capture-DR clears it to 0, and `tdo_o` repeats `tdi_i` one clock later.
- R9: When `ctrl_o[24]`=1, `tdo_o` in shift-DR comes from `dr_tdo_i`. `dr_capture_o`, `dr_shift_o` and `dr_update_o` are high in capture-DR, shift-DR and update-DR respectively, and only when `ctrl_o[24]`=1.
- R10: `tdo_o` and `tdo_en_o` change on the falling edge of `tck_i`. `tdo_en_o` is high only while in shift-IR or shift-DR, and outside those states both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | System reset, active low; gates the test reset |
| trst_ni | input | 1 | Test reset, active low; acts only while `rst_ni` is low |
| tms_i | input | 1 | Mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in |
| dr_tdo_i | input | 1 | Serial output of the external data register |
| tdo_o | output | 1 | Serial data out, updated on falling `tck_i` |
| tdo_en_o | output | 1 | Output enable for `tdo_o` |
| ctrl_o | output | 25 | Committed instruction bits; bit 24 selects the external data register |
| state_o | output | 4 | Controller state code |
| dr_capture_o | output | 1 | External data register capture strobe |
| dr_shift_o | output | 1 | External data register shift strobe |
| dr_update_o | output | 1 | External data register update strobe |

## Verification
The hardest case to reach is the reset gating. Showing that `trst_ni` does nothing needs a controller that is away from state 0 and holds nonzero controls. So the bench first commits a nonzero instruction, parks the controller in idle, and then pulls each reset low on its own while it keeps clocking. It checks that neither the state nor `ctrl_o` moved before it drops both resets together. To sweep every state transition, the bench walks a known `tms_i` path to each state and applies each `tms_i` value from there. The over-length scan shifts 30 bits and then looks both at the bits that come out on `tdo_o` and at the committed value.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SHF_DR  = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SHF_IR  = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

  localparam int unsigned RESET_TMS_RUN = 5;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms_i ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // run-length of tms high, for the reset-reach check
  logic [2:0] ones_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          ones_q <= '0;
    else if (!tms_i)                      ones_q <= '0;
    else if (ones_q != 3'(RESET_TMS_RUN)) ones_q <= ones_q + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'(RESET_TMS_RUN)) |-> (state_q == ST_RESET)); // R2

  AST_SHIFT_DR_ENTRY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_SHF_DR && !$past(state_q == ST_SHF_DR)) |->
      ($past(state_q == ST_CAP_DR) || $past(state_q == ST_EX2_DR))); // R1

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int unsigned       IR_LEN = 25,
  parameter logic [IR_LEN-1:0] IR_RST = '0
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  tap_state_e        state_i,
  output logic              ir_lsb_o,
  output logic [IR_LEN-1:0] ctrl_o
);

  localparam logic [IR_LEN-1:0] CAP_PAT = {{(IR_LEN-2){1'b0}}, 2'b01};

  logic [IR_LEN-1:0] sr_q;
  logic [IR_LEN-1:0] shadow_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= CAP_PAT;
    end else begin
      case (state_i)
        ST_CAP_IR: sr_q <= CAP_PAT;
        ST_SHF_IR: sr_q <= {tdi_i, sr_q[IR_LEN-1:1]};
        default:   sr_q <= sr_q;
      endcase
    end
  end

  // committed copy; shifting never disturbs it
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                    shadow_q <= IR_RST;
    else if (state_i == ST_RESET)   shadow_q <= IR_RST;
    else if (state_i == ST_UPD_IR)  shadow_q <= sr_q;
  end

  assign ir_lsb_o = sr_q[0];
  assign ctrl_o   = shadow_q;

  AST_CAPTURE_PATTERN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_IR) |=> (sr_q == CAP_PAT)); // R4

  AST_SHIFT_KEEPS_CTRL: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SHF_IR) |=> $stable(ctrl_o)); // R6

  AST_RESET_STATE_CLEARS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_RESET) |=> (ctrl_o == IR_RST)); // R7

  AST_SHIFT_IN_MSB: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SHF_IR) |=> (sr_q[IR_LEN-1] == $past(tdi_i))); // R5

endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  input  logic       ext_sel_i,
  input  logic       dr_tdo_i,
  input  logic       ir_lsb_i,
  output logic       tdo_o,
  output logic       tdo_en_o,
  output logic       dr_capture_o,
  output logic       dr_shift_o,
  output logic       dr_update_o
);

  logic byp_q;
  logic tdo_q, tdo_en_q;
  logic shf_ir, shf_dr;

  assign shf_ir = (state_i == ST_SHF_IR);
  assign shf_dr = (state_i == ST_SHF_DR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   byp_q <= 1'b0;
    else if (state_i == ST_CAP_DR) byp_q <= 1'b0;
    else if (shf_dr)               byp_q <= tdi_i;
  end

  // output retimed to the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= shf_ir | shf_dr;
      if (shf_ir)      tdo_q <= ir_lsb_i;
      else if (shf_dr) tdo_q <= ext_sel_i ? dr_tdo_i : byp_q;
      else             tdo_q <= 1'b0;
    end
  end

  assign tdo_o        = tdo_q;
  assign tdo_en_o     = tdo_en_q;
  assign dr_capture_o = ext_sel_i && (state_i == ST_CAP_DR);
  assign dr_shift_o   = ext_sel_i && shf_dr;
  assign dr_update_o  = ext_sel_i && (state_i == ST_UPD_DR);

  AST_BYPASS_CAPTURE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR) |=> (byp_q == 1'b0)); // R8

  AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> (shf_ir || shf_dr)); // R10

  AST_TDO_QUIET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_en_o |-> !tdo_o); // R10

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int unsigned       IR_LEN  = 25,
  parameter int unsigned       SEL_BIT = IR_LEN - 1,
  parameter logic [IR_LEN-1:0] IR_RST  = '0
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              trst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic              dr_tdo_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  output logic [IR_LEN-1:0] ctrl_o,
  output logic [3:0]        state_o,
  output logic              dr_capture_o,
  output logic              dr_shift_o,
  output logic              dr_update_o
);

  // test reset acts only while system reset is held
  logic       tap_rst_n;
  tap_state_e state;
  logic       ir_lsb;

  assign tap_rst_n = rst_ni | trst_ni;

  tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (tap_rst_n),
    .tms_i  (tms_i),
    .state_o(state)
  );

  tap_ir #(
    .IR_LEN(IR_LEN),
    .IR_RST(IR_RST)
  ) u_ir (
    .tck_i   (tck_i),
    .rst_ni  (tap_rst_n),
    .tdi_i   (tdi_i),
    .state_i (state),
    .ir_lsb_o(ir_lsb),
    .ctrl_o  (ctrl_o)
  );

  tap_dr_path u_dr (
    .tck_i       (tck_i),
    .rst_ni      (tap_rst_n),
    .tdi_i       (tdi_i),
    .state_i     (state),
    .ext_sel_i   (ctrl_o[SEL_BIT]),
    .dr_tdo_i    (dr_tdo_i),
    .ir_lsb_i    (ir_lsb),
    .tdo_o       (tdo_o),
    .tdo_en_o    (tdo_en_o),
    .dr_capture_o(dr_capture_o),
    .dr_shift_o  (dr_shift_o),
    .dr_update_o (dr_update_o)
  );

  assign state_o = state;

  AST_CTRL_ONLY_AT_UPDATE: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    !$stable(ctrl_o) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET)); // R6

endmodule

// File: tb/tb_jtag_tap_ctrl.sv
module tb_jtag_tap_ctrl;

  localparam time CLK_P = 20ns;

  logic        tck_i = 1'b0;
  logic        rst_ni, trst_ni, tms_i, tdi_i, dr_tdo_i;
  logic        tdo_o, tdo_en_o, dr_capture_o, dr_shift_o, dr_update_o;
  logic [24:0] ctrl_o;
  logic [3:0]  state_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) tck_i = ~tck_i;

  jtag_tap_ctrl dut (
    .tck_i(tck_i), .rst_ni(rst_ni), .trst_ni(trst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .dr_tdo_i(dr_tdo_i), .tdo_o(tdo_o), .tdo_en_o(tdo_en_o), .ctrl_o(ctrl_o),
    .state_o(state_o), .dr_capture_o(dr_capture_o), .dr_shift_o(dr_shift_o),
    .dr_update_o(dr_update_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi);
    tms_i = tms;
    tdi_i = tdi;
    @(posedge tck_i);
    @(negedge tck_i);
    #1;
  endtask

  function automatic int nxt(input int s, input bit t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  function automatic string path_to(input int s);
    case (s)
      0: return "";        1: return "0";       2: return "01";
      3: return "010";     4: return "0100";    5: return "0101";
      6: return "01010";   7: return "010101";  8: return "01011";
      9: return "011";     10: return "0110";   11: return "01100";
      12: return "01101";  13: return "011010"; 14: return "0110101";
      default: return "011011";
    endcase
  endfunction

  task automatic five_ones();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
  endtask

  // from idle: scan n bits into IR, commit, return to idle
  task automatic scan_ir(input logic [63:0] bits, input int n, output logic [63:0] outb);
    logic [24:0] old;
    old  = ctrl_o;
    outb = '0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      outb[i] = tdo_o;
      tick(i == n - 1, bits[i]);
    end
    chk("R6 ctrl held through shift", ctrl_o, old);
    tick(1, 0);
    chk("R6 state update-IR", state_o, 15);
    chk("R6 ctrl held in update-IR", ctrl_o, old);
    tick(0, 0);
  endtask

  task automatic t_reset_state();
    chk("R3 reset state", state_o, 0);
    chk("R3 reset ctrl", ctrl_o, 0);
    chk("R10 reset tdo_en", tdo_en_o, 0);
    chk("R10 reset tdo", tdo_o, 0);
  endtask

  task automatic t_transitions();
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 2; b++) begin
        string p;
        five_ones();
        chk("R2 five ones reach reset", state_o, 0);
        p = path_to(s);
        for (int i = 0; i < p.len(); i++) tick(p[i] == 8'h31, 1'b0);
        chk("R1 path reaches state", state_o, s);
        tick(b[0], 1'b0);
        chk("R1 transition", state_o, nxt(s, b[0]));
        five_ones();
        chk("R2 five ones from any state", state_o, 0);
      end
    end
    tick(0, 0);
  endtask

  task automatic t_ir_capture_and_load();
    logic [63:0] outb;
    logic [24:0] v;
    v = 25'h0A5_3C96;
    scan_ir({39'd0, v}, 25, outb);
    chk("R4 captured pattern on tdo", outb[24:0], 25'h1);
    chk("R5 lsb-first load", ctrl_o, v);
    chk("R1 back in idle", state_o, 1);
  endtask

  task automatic t_ir_overlong();
    logic [63:0] outb;
    logic [63:0] bits;
    bits = 64'h0000_0000_2B7E_1519;
    scan_ir(bits, 30, outb);
    chk("R5 keeps last 25 bits", ctrl_o, bits[29:5]);
    chk("R5 early bits pass through to tdo", outb[29:25], bits[4:0]);
    chk("R4 capture in overlong scan", outb[1:0], 2'b01);
  endtask

  task automatic t_tlr_clears();
    five_ones();
    tick(1, 0);
    chk("R7 reset state clears ctrl", ctrl_o, 0);
    tick(0, 0);
  endtask

  task automatic t_bypass();
    tick(1, 0); tick(0, 0);
    chk("R9 no capture strobe in bypass", dr_capture_o, 0);
    dr_tdo_i = 1'b1;
    tick(0, 0);
    chk("R8 bypass captured 0", tdo_o, 0);
    chk("R10 tdo_en in shift-DR", tdo_en_o, 1);
    chk("R9 no shift strobe in bypass", dr_shift_o, 0);
    tms_i = 0; tdi_i = 1;
    @(posedge tck_i); #1;
    chk("R10 tdo held until falling edge", tdo_o, 0);
    @(negedge tck_i); #1;
    chk("R8 bypass one-clock delay", tdo_o, 1);
    tick(0, 0); chk("R8 bypass bit 0", tdo_o, 0);
    tick(0, 1); chk("R8 bypass bit 1", tdo_o, 1);
    tick(1, 0);
    chk("R10 tdo_en low in exit1", tdo_en_o, 0);
    chk("R10 tdo low in exit1", tdo_o, 0);
    tick(1, 0); tick(0, 0);
    dr_tdo_i = 1'b0;
  endtask

  task automatic t_ext_dr();
    logic [63:0] outb;
    scan_ir({39'd0, 25'h100_0001}, 25, outb);
    chk("R9 select bit committed", ctrl_o[24], 1);
    tick(1, 0); tick(0, 0);
    chk("R9 capture strobe", dr_capture_o, 1);
    dr_tdo_i = 1'b1;
    tick(0, 0);
    chk("R9 shift strobe", dr_shift_o, 1);
    chk("R9 tdo from external", tdo_o, 1);
    dr_tdo_i = 1'b0;
    tick(0, 1);
    chk("R9 tdo follows external", tdo_o, 0);
    tick(1, 0);
    chk("R9 shift strobe off in exit1", dr_shift_o, 0);
    tick(1, 0);
    chk("R9 update strobe", dr_update_o, 1);
    tick(0, 0);
    chk("R9 update strobe off in idle", dr_update_o, 0);
  endtask

  task automatic t_reset_gating();
    logic [63:0] outb;
    logic [24:0] v;
    v = 25'h04C_1D2B;
    scan_ir({39'd0, v}, 25, outb);
    chk("R3 setup ctrl", ctrl_o, v);
    trst_ni = 1'b0;
    tick(0, 0); tick(0, 0);
    chk("R3 trst ignored: state", state_o, 1);
    chk("R3 trst ignored: ctrl", ctrl_o, v);
    trst_ni = 1'b1;
    rst_ni  = 1'b0;
    tick(0, 0);
    chk("R3 system reset alone: state", state_o, 1);
    chk("R3 system reset alone: ctrl", ctrl_o, v);
    trst_ni = 1'b0;
    #1;
    chk("R3 both low: state", state_o, 0);
    chk("R3 both low: ctrl", ctrl_o, 0);
    @(negedge tck_i);
    rst_ni  = 1'b1;
    trst_ni = 1'b1;
    #1;
    tick(0, 0);
  endtask

  initial begin
    rst_ni = 0; trst_ni = 0; tms_i = 1; tdi_i = 0; dr_tdo_i = 0;
    repeat (2) @(negedge tck_i);
    #1;
    t_reset_state();
    rst_ni = 1; trst_ni = 1;
    tick(0, 0);
    t_transitions();
    t_ir_capture_and_load();
    t_ir_overlong();
    t_tlr_clears();
    t_bypass();
    t_ext_dr();
    t_reset_gating();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule